// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. Pins are grouped in banks of 32, and each bank has its own copy of the register set at a fixed address stride. Software drives pins by setting an output-enable bit and a data-output bit. It reads synchronized pin levels, sets a pull-up or pull-down for each pad, and picks a 3-bit drive-strength code for each pad. The pad controls leave the block as plain per-pin outputs that go to the pad cells.

Every pin has an interrupt detector. Three independent per-pin bits select its trigger: sensing type, dual-edge enable and polarity. A detected event latches into a raw status bit whether or not the pin is masked. Software reads raw or masked status, clears status bits by writing ones, and sees one combined interrupt line that is the OR of every unmasked pending bit in every bank.

The register port is a single-cycle interface. A write lands on the clock edge where `reg_wr` is high. Read data is a combinational function of the address.

Top module: `gpio_ctrl`

## Requirements
- R1: Byte address bits [8:0] select a register inside a bank and the bits above select the bank (stride 0x200). Pin n sits in bank n/32 at bit n%32. Offsets outside the map read as zero.
- R2: Data-output (offset 0x04) and output-enable (0x08) are read/write. `pin_out` and `pin_oe` carry their bits (1 = drive the pin), and the output enable changes only on a write to 0x08.
- R3: Offset 0x00 reads pin levels through a two-flop synchronizer. A change on `pin_in` just before a clock edge is readable after the second edge, and writes to 0x00 are ignored.
- R4: With the type bit (0x0C) at 1 the pin is level sensed: polarity (0x14) 1 means high, 0 means low. Status is set on every cycle the active level is present, including the cycle right after a clear.
- R5: With the type bit at 0 and dual-edge (0x10) at 0, polarity 1 detects a rising edge and 0 a falling edge. Status is set on the third clock edge after the pin changes, and the opposite edge sets nothing.
- R6: With the type bit at 0 and dual-edge at 1, both rising and falling edges set status.
- R7: Raw status (0x1C) latches events even when the mask bit (0x18) is 0. Masked status (0x20) reads raw AND mask. Status bits never drop except through a clear.
- R8: Writing 1 to a bit of the clear word (0x24) clears that status bit and 0 bits leave status alone. When an event and a clear hit the same bit in one cycle the event wins, and 0x24 reads as zero.
- R9: `irq` is high exactly when any masked-status bit in any bank is 1.
- R10: Pull enable (0x38) and pull select (0x34) are read/write. `pad_pu` = enable AND select, `pad_pd` = enable AND NOT select.
- R11: Drive-strength bit i of a pin is stored in the word at 0x58 + 4*i (i = 0..2). `drive_code[3n+2:3n]` carries the code for pin n, and code k means (k+1)*2 mA.
- R12: Reset clears every register: inputs only, interrupts masked, no pull, code 0. Writes to raw status (0x1C) and masked status (0x20) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (10) | Byte address: bank index above bit 8, register offset below |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pin_in | input | NPINS (64) | Pad input levels, asynchronous |
| pin_out | output | NPINS | Value driven on each pin when enabled |
| pin_oe | output | NPINS | Per-pin output enable |
| pad_pu | output | NPINS | Pull-up request per pad |
| pad_pd | output | NPINS | Pull-down request per pad |
| drive_code | output | 3*NPINS | 3-bit drive-strength code per pad |
| irq | output | 1 | Combined interrupt, OR of all masked status |

## Verification
The assertions check four rules on every cycle. A cleared status bit with no coincident event reads 0 next cycle, no status bit falls without a clear, an event always shows up in status one edge later, and output enable holds between its writes. Reads of unmapped offsets are also checked on every cycle to return zero. Only the bench scenarios show the trigger decoding: which pin waveforms produce events under each type, dual-edge and polarity setting, the two-edge synchronizer delay, the level re-assertion after a clear, and the mapping of bit planes onto per-pin drive codes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int OFS_W         = 9;
  localparam int DRV_BITS      = 3;

  localparam logic [OFS_W-1:0] OFS_DIN   = 9'h000;
  localparam logic [OFS_W-1:0] OFS_DOUT  = 9'h004;
  localparam logic [OFS_W-1:0] OFS_OE    = 9'h008;
  localparam logic [OFS_W-1:0] OFS_TYPE  = 9'h00C;
  localparam logic [OFS_W-1:0] OFS_DUAL  = 9'h010;
  localparam logic [OFS_W-1:0] OFS_POL   = 9'h014;
  localparam logic [OFS_W-1:0] OFS_MASK  = 9'h018;
  localparam logic [OFS_W-1:0] OFS_RAW   = 9'h01C;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 9'h020;
  localparam logic [OFS_W-1:0] OFS_CLR   = 9'h024;
  localparam logic [OFS_W-1:0] OFS_PSEL  = 9'h034;
  localparam logic [OFS_W-1:0] OFS_PEN   = 9'h038;
  localparam logic [OFS_W-1:0] OFS_DRV0  = 9'h058;

  typedef logic [PINS_PER_BANK-1:0] lane_t;

  // Word offset of drive-strength bit plane i.
  function automatic logic [OFS_W-1:0] drv_plane_ofs(input int i);
    return OFS_DRV0 + OFS_W'(4 * i);
  endfunction

  // Per-pin trigger decision from current/previous sampled level and config.
  function automatic lane_t trig_hits(input lane_t cur, input lane_t prv,
                                      input lane_t lvl, input lane_t dual,
                                      input lane_t pol);
    lane_t rise, fall, edge_hit, lvl_hit;
    rise     = cur & ~prv;
    fall     = ~cur & prv;
    edge_hit = (dual & (rise | fall)) | (~dual & ((pol & rise) | (~pol & fall)));
    lvl_hit  = (pol & cur) | (~pol & ~cur);
    return (lvl & lvl_hit) | (~lvl & edge_hit);
  endfunction

  // True when an in-bank offset names a register (readable or clear word).
  function automatic logic ofs_mapped(input logic [OFS_W-1:0] ofs);
    logic hit;
    hit = (ofs == OFS_DIN) || (ofs == OFS_DOUT) || (ofs == OFS_OE) ||
          (ofs == OFS_TYPE) || (ofs == OFS_DUAL) || (ofs == OFS_POL) ||
          (ofs == OFS_MASK) || (ofs == OFS_RAW) || (ofs == OFS_MSTAT) ||
          (ofs == OFS_CLR) || (ofs == OFS_PSEL) || (ofs == OFS_PEN);
    for (int i = 0; i < DRV_BITS; i++) hit = hit || (ofs == drv_plane_ofs(i));
    return hit;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] level_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= '0;
      level      <= '0;
      level_prev <= '0;
    end else begin
      meta_q     <= async_in;
      level      <= meta_q;
      level_prev <= level;
    end
  end
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t cur,
  input  lane_t prv,
  input  lane_t cfg_level,
  input  lane_t cfg_dual,
  input  lane_t cfg_pol,
  input  lane_t clr,
  output lane_t status
);
  lane_t hit;

  assign hit = trig_hits(cur, prv, cfg_level, cfg_dual, cfg_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | hit;
  end

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((status & $past(clr) & ~$past(hit)) == '0));
  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~status) & ~$past(clr)) == '0));
  // R4
  event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [OFS_W-1:0]            ofs,
  input  logic [31:0]                 wdata,
  input  lane_t                       pins_in,
  output logic [31:0]                 rdata,
  output lane_t                       dout,
  output lane_t                       oe,
  output lane_t                       pu,
  output lane_t                       pd,
  output logic [DRV_BITS*PINS_PER_BANK-1:0] drv,
  output logic                        irq_any
);
  lane_t typ_q, dual_q, pol_q, mask_q, psel_q, pen_q;
  lane_t din, din_prev, status, clr;
  lane_t drv_pl [DRV_BITS];

  gpio_sync #(.W(PINS_PER_BANK)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_in),
    .level(din), .level_prev(din_prev)
  );

  assign clr = (wr && ofs == OFS_CLR) ? wdata : '0;

  gpio_irq_det u_det (
    .clk(clk), .rst_n(rst_n), .cur(din), .prv(din_prev),
    .cfg_level(typ_q), .cfg_dual(dual_q), .cfg_pol(pol_q),
    .clr(clr), .status(status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; oe <= '0; typ_q <= '0; dual_q <= '0;
      pol_q <= '0; mask_q <= '0; psel_q <= '0; pen_q <= '0;
    end else if (wr) begin
      case (ofs)
        OFS_DOUT: dout   <= wdata;
        OFS_OE:   oe     <= wdata;
        OFS_TYPE: typ_q  <= wdata;
        OFS_DUAL: dual_q <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_MASK: mask_q <= wdata;
        OFS_PSEL: psel_q <= wdata;
        OFS_PEN:  pen_q  <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < DRV_BITS; i++) begin : g_plane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               drv_pl[i] <= '0;
      else if (wr && ofs == drv_plane_ofs(i))   drv_pl[i] <= wdata;
    end
    for (genvar p = 0; p < PINS_PER_BANK; p++) begin : g_pin
      assign drv[DRV_BITS*p + i] = drv_pl[i][p];
    end
  end

  assign pu      = pen_q & psel_q;
  assign pd      = pen_q & ~psel_q;
  assign irq_any = |(status & mask_q);

  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_DIN:   rdata = din;
      OFS_DOUT:  rdata = dout;
      OFS_OE:    rdata = oe;
      OFS_TYPE:  rdata = typ_q;
      OFS_DUAL:  rdata = dual_q;
      OFS_POL:   rdata = pol_q;
      OFS_MASK:  rdata = mask_q;
      OFS_RAW:   rdata = status;
      OFS_MSTAT: rdata = status & mask_q;
      OFS_PSEL:  rdata = psel_q;
      OFS_PEN:   rdata = pen_q;
      default: ;
    endcase
    for (int i = 0; i < DRV_BITS; i++)
      if (ofs == drv_plane_ofs(i)) rdata = drv_pl[i];
  end

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && ofs == OFS_OE) |=> $stable(oe));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int NPINS    = PINS_PER_BANK * NUM_BANKS,
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = OFS_W + BSEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NPINS-1:0]          pin_in,
  output logic [NPINS-1:0]          pin_out,
  output logic [NPINS-1:0]          pin_oe,
  output logic [NPINS-1:0]          pad_pu,
  output logic [NPINS-1:0]          pad_pd,
  output logic [DRV_BITS*NPINS-1:0] drive_code,
  output logic                      irq
);
  localparam int DRV_PER_BANK = DRV_BITS * PINS_PER_BANK;

  logic [BSEL_W-1:0]    bank_idx;
  logic [OFS_W-1:0]     ofs;
  logic [31:0]          bank_rd  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  assign bank_idx = reg_addr[ADDR_W-1:OFS_W];
  assign ofs      = reg_addr[OFS_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr && bank_idx == BSEL_W'(b)),
      .ofs(ofs), .wdata(reg_wdata),
      .pins_in(pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .rdata(bank_rd[b]),
      .dout(pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .oe(pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pu(pad_pu[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pd(pad_pd[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .drv(drive_code[b*DRV_PER_BANK +: DRV_PER_BANK]),
      .irq_any(bank_irq[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx == BSEL_W'(b)) reg_rdata = bank_rd[b];
  end

  assign irq = |bank_irq;

  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_mapped(ofs) |-> (reg_rdata == 32'h0));
endmodule

// File: tb/gpio_ctrl_test.sv
`timescale 1ns/1ps
module gpio_ctrl_test;
  localparam int NB = 2;
  localparam int NP = 32 * NB;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [9:0]      reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NP-1:0]   pin_in = '0;
  logic [NP-1:0]   pin_out, pin_oe, pad_pu, pad_pd;
  logic [3*NP-1:0] drive_code;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .drive_code(drive_code), .irq(irq)
  );

  // Register write, then readback, with the expected readback value.
  localparam int NV = 16;
  localparam logic [9:0] TA [NV] = '{
    10'h004, 10'h008, 10'h018, 10'h034, 10'h038, 10'h058, 10'h05C, 10'h060,
    10'h204, 10'h208, 10'h000, 10'h01C, 10'h020, 10'h024, 10'h040, 10'h214};
  localparam logic [31:0] TW [NV] = '{
    32'hA5A50F0F, 32'hFFFF0000, 32'h000000FF, 32'h0000000A, 32'h0000000C,
    32'h00000001, 32'h00000003, 32'h00000002, 32'h12345678, 32'h0000FFFF,
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'h000000F0};
  localparam logic [31:0] TE [NV] = '{
    32'hA5A50F0F, 32'hFFFF0000, 32'h000000FF, 32'h0000000A, 32'h0000000C,
    32'h00000001, 32'h00000003, 32'h00000002, 32'h12345678, 32'h0000FFFF,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000,
    32'h000000F0};
  localparam string TR [NV] = '{
    "R2", "R2", "R7", "R10", "R10", "R11", "R11", "R11",
    "R1", "R1", "R3", "R12", "R12", "R8", "R1", "R1"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; pin_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R12 reset state
    check("R12 oe", pin_oe[31:0], 32'h0);
    check("R12 out", pin_out[63:32], 32'h0);
    check("R12 pull", pad_pu[31:0] | pad_pd[31:0], 32'h0);
    check("R12 drive", drive_code[31:0], 32'h0);
    check("R12 irq", {31'b0, irq}, 32'h0);
    rd(10'h018, v); check("R12 mask", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(TA[i], TW[i]);
      rd(TA[i], v);
      check(TR[i], v, TE[i]);
    end
    check("R2 pin_out b0", pin_out[31:0], 32'hA5A50F0F);
    check("R1 pin_out b1", pin_out[63:32], 32'h12345678);
    check("R1 pin_oe b1", pin_oe[63:32], 32'h0000FFFF);
    check("R10 pu", {28'b0, pad_pu[3:0]}, 32'h8);
    check("R10 pd", {28'b0, pad_pd[3:0]}, 32'h4);
    check("R11 pin0 code", {29'b0, drive_code[2:0]}, 32'h3);
    check("R11 pin1 code", {29'b0, drive_code[5:3]}, 32'h6);
    check("R9 irq idle", {31'b0, irq}, 32'h0);

    // R3 synchronizer delay
    do_reset();
    pin_in[3] = 1'b1;
    cyc(1); rd(10'h000, v); check("R3 one edge", v, 32'h0);
    cyc(1); rd(10'h000, v); check("R3 two edges", v, 32'h8);

    // R5 rising edge, clear behaviour
    do_reset();
    wr(10'h014, 32'h20); wr(10'h018, 32'h20);
    pin_in[5] = 1'b1;
    cyc(2); rd(10'h01C, v); check("R5 rise early", v, 32'h0);
    cyc(1); rd(10'h01C, v); check("R5 rise latched", v, 32'h20);
    rd(10'h020, v); check("R7 masked", v, 32'h20);
    check("R9 irq set", {31'b0, irq}, 32'h1);
    wr(10'h024, 32'hFFFFFFDF); rd(10'h01C, v); check("R8 zero bits", v, 32'h20);
    wr(10'h024, 32'h20); rd(10'h01C, v); check("R8 cleared", v, 32'h0);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
    pin_in[5] = 1'b0;
    cyc(4); rd(10'h01C, v); check("R5 falling ignored", v, 32'h0);

    // R5 falling edge, R7 mask
    do_reset();
    pin_in[6] = 1'b1;
    cyc(4); rd(10'h01C, v); check("R5 rise ignored", v, 32'h0);
    pin_in[6] = 1'b0;
    cyc(3); rd(10'h01C, v); check("R5 fall latched", v, 32'h40);
    rd(10'h020, v); check("R7 masked off", v, 32'h0);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(10'h018, 32'h40);
    rd(10'h020, v); check("R7 masked on", v, 32'h40);
    check("R9 irq unmasked", {31'b0, irq}, 32'h1);

    // R6 dual edge
    do_reset();
    wr(10'h010, 32'h80);
    pin_in[7] = 1'b1;
    cyc(3); rd(10'h01C, v); check("R6 rise", v, 32'h80);
    wr(10'h024, 32'h80);
    pin_in[7] = 1'b0;
    cyc(3); rd(10'h01C, v); check("R6 fall", v, 32'h80);

    // R4 level low and high
    do_reset();
    wr(10'h014, 32'h200); wr(10'h00C, 32'h300);
    cyc(1); rd(10'h01C, v); check("R4 level low", v, 32'h100);
    wr(10'h024, 32'h100); rd(10'h01C, v); check("R8 event wins", v, 32'h100);
    pin_in[8] = 1'b1;
    cyc(3); rd(10'h01C, v); check("R4 sticky", v, 32'h100);
    wr(10'h024, 32'h100); rd(10'h01C, v); check("R4 inactive clear", v, 32'h0);
    pin_in[9] = 1'b1;
    cyc(3); rd(10'h01C, v); check("R4 level high", v, 32'h200);

    // R1 second bank interrupt
    do_reset();
    wr(10'h214, 32'h2); wr(10'h218, 32'h2);
    pin_in[33] = 1'b1;
    cyc(3); rd(10'h21C, v); check("R1 bank1 status", v, 32'h2);
    rd(10'h01C, v); check("R1 bank0 untouched", v, 32'h0);
    check("R9 bank1 irq", {31'b0, irq}, 32'h1);

    finish_run();
  end
endmodule